// File: doc/BRIEF.md
# Row-Serial Template Multiply-Accumulate Core

This block is the arithmetic core of a cellular neural network cell-update engine that uses a template of arbitrary odd size. The template is (2n+1)×(2n+1). Each clock cycle the block accepts one template row and the matching row of neighbouring state values. It multiplies them lane by lane in 2n+1 pipelined multipliers and reduces the products with a registered adder tree. The sums of successive rows are accumulated. After the last row of a cell, the cell's old state x and its constant g are added. Both were presented with the first row and held back by a fixed-length delay line. The total is then saturated to the state width.

A new cell value is produced every 2n+1 cycles when cells are streamed back to back, and the multipliers stay busy on every cycle. Window formation and template storage sit outside this block. An upstream unit presents the rows of one cell on consecutive cycles. It may pause between cells.

Top module: `tmac_row_unit`

## Requirements
- R1: While `rst_ni` is low and after its release until the first completed cell, `result_valid_o` is 0 and `result_o` is 0.
- R2: For each cell, `result_o` = sat(x + g + floor(Σ T·S / 2^FRAC)), all in two's complement. T is the template element, S is the matching state element, summed over all (2n+1)² positions. Lane j of a row occupies bits [j*W +: W] of its port. x and g are the `old_state_i` and `const_i` values sampled together with the first row of the cell.
- R3: The sum saturates to the range [−2^(SW−1), 2^(SW−1)−1]. A sum lying exactly on either bound passes unchanged.
- R4: `result_valid_o` is a one-cycle pulse for each completed cell. It is raised LAT = 2n + MUL_LAT + ceil(log2(2n+1)) clock edges after the edge that accepted the cell's first row. `result_o` changes only together with that pulse.
- R5: Cells streamed with no idle cycle between them each produce a correct result, one every 2n+1 cycles. The accumulator restarts on each first row, so nothing carries over between cells.
- R6: A row is consumed only when `row_valid_i` is 1. The 2n+1 rows of a cell must arrive on consecutive cycles. Any number of idle cycles may separate cells. Inputs on idle cycles produce no output and do not change any later result.
- R7: `old_state_i` and `const_i` are ignored on every row except the first of a cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_valid_i | input | 1 | A template row and state row are present |
| tmpl_row_i | input | K*TW (80) | Template row, K=2n+1 signed lanes |
| state_row_i | input | K*SW (80) | State row, K signed lanes |
| const_i | input | CW (16) | Cell constant g, sampled with the first row |
| old_state_i | input | SW (16) | Old cell state x, sampled with the first row |
| result_o | output | SW (16) | New cell state, saturated |
| result_valid_o | output | 1 | One-cycle pulse per finished cell |

## Verification
A template whose only nonzero element is 1.0 at the centre tap isolates the data path from the accumulation. Any lane-mapping or fractional-shift error shows up directly as a wrong pass-through value. Random cells sent back to back separate a correct load-on-first accumulator from one that leaks a partial sum into the next cell, and they fix the LAT-cycle output timing. Cells are also sent with idle gaps that carry junk data, and with x/g changing on later rows, to show that only valid first-row data reaches the result. Sums pushed beyond and exactly onto each saturation bound tell clamping apart from wraparound and from off-by-one limits.

// File: rtl/tmac_pkg.sv
package tmac_pkg;
  typedef struct packed {
    logic valid;
    logic first;
    logic last;
  } row_tag_t;
endpackage

// File: rtl/tmac_row_seq.sv
module tmac_row_seq #(
  parameter int K = 5,
  localparam int RW = (K > 1) ? $clog2(K) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  output logic [RW-1:0] row_o,
  output logic          first_o,
  output logic          last_o
);
  localparam logic [RW-1:0] LAST_ROW = RW'(K - 1);

  logic [RW-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) row_q <= '0;
    else if (valid_i) row_q <= (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
  end

  assign row_o   = row_q;
  assign first_o = valid_i && (row_q == '0);
  assign last_o  = valid_i && (row_q == LAST_ROW);
endmodule

// File: rtl/tmac_mul_lane.sv
module tmac_mul_lane #(
  parameter int AW  = 16,
  parameter int BW  = 16,
  parameter int LAT = 2,
  localparam int PW = AW + BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic [PW-1:0] p_o
);
  logic signed [PW-1:0] p_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < LAT; k++) p_q[k] <= '0;
    end else begin
      p_q[0] <= $signed(a_i) * $signed(b_i);
      for (int k = 1; k < LAT; k++) p_q[k] <= p_q[k-1];
    end
  end

  assign p_o = p_q[LAT-1];
endmodule

// File: rtl/tmac_adder_tree.sv
module tmac_adder_tree #(
  parameter int N  = 5,
  parameter int IW = 32,
  parameter int OW = 38,
  localparam int LVL = (N > 1) ? $clog2(N) : 1,
  localparam int NP  = 1 << LVL
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N*IW-1:0] in_i,
  output logic [OW-1:0] sum_o
);
  logic signed [OW-1:0] leaf [NP];

  always_comb begin
    for (int i = 0; i < NP; i++) leaf[i] = '0;
    for (int i = 0; i < N; i++) leaf[i] = OW'($signed(in_i[i*IW +: IW]));
  end

  for (genvar l = 0; l < LVL; l++) begin : g_lvl
    localparam int NN = NP >> (l + 1);
    logic signed [OW-1:0] s_q [NN];
    if (l == 0) begin : g_leaf
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) for (int i = 0; i < NN; i++) s_q[i] <= '0;
        else for (int i = 0; i < NN; i++) s_q[i] <= leaf[2*i] + leaf[2*i+1];
      end
    end else begin : g_node
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) for (int i = 0; i < NN; i++) s_q[i] <= '0;
        else for (int i = 0; i < NN; i++)
          s_q[i] <= g_lvl[l-1].s_q[2*i] + g_lvl[l-1].s_q[2*i+1];
      end
    end
  end

  assign sum_o = g_lvl[LVL-1].s_q[0];
endmodule

// File: rtl/tmac_delay.sv
module tmac_delay #(
  parameter int W = 8,
  parameter int D = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] sr_q [D];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < D; k++) sr_q[k] <= '0;
    end else begin
      sr_q[0] <= d_i;
      for (int k = 1; k < D; k++) sr_q[k] <= sr_q[k-1];
    end
  end

  assign q_o = sr_q[D-1];
endmodule

// File: rtl/tmac_row_unit.sv
module tmac_row_unit
  import tmac_pkg::*;
#(
  parameter int NBH     = 2,
  parameter int SW      = 16,
  parameter int TW      = 16,
  parameter int CW      = 16,
  parameter int FRAC    = 8,
  parameter int MUL_LAT = 2,
  localparam int K      = 2 * NBH + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            row_valid_i,
  input  logic [K*TW-1:0] tmpl_row_i,
  input  logic [K*SW-1:0] state_row_i,
  input  logic [CW-1:0]   const_i,
  input  logic [SW-1:0]   old_state_i,
  output logic [SW-1:0]   result_o,
  output logic            result_valid_o
);
  localparam int LVL   = $clog2(K);
  localparam int PW    = TW + SW;
  localparam int AW    = PW + 2 * LVL;
  localparam int RW    = AW + 2;
  localparam int PIPE  = MUL_LAT + LVL;
  localparam int LAT   = K - 1 + PIPE;
  localparam int RIW   = $clog2(K);
  localparam longint SMAX = (longint'(1) << (SW - 1)) - 1;
  localparam longint SMIN = -SMAX - 1;

  logic [RIW-1:0] row_idx;
  logic           first_row, last_row;

  tmac_row_seq #(.K(K)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (row_valid_i),
    .row_o   (row_idx),
    .first_o (first_row),
    .last_o  (last_row)
  );

  logic [K*PW-1:0] prod;

  for (genvar j = 0; j < K; j++) begin : g_lane
    tmac_mul_lane #(.AW(TW), .BW(SW), .LAT(MUL_LAT)) u_mul (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .a_i    (tmpl_row_i[j*TW +: TW]),
      .b_i    (state_row_i[j*SW +: SW]),
      .p_o    (prod[j*PW +: PW])
    );
  end

  logic [AW-1:0] row_sum;

  tmac_adder_tree #(.N(K), .IW(PW), .OW(AW)) u_tree (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (prod),
    .sum_o  (row_sum)
  );

  row_tag_t tag_in, tag_d;
  assign tag_in = '{valid: row_valid_i, first: first_row, last: last_row};

  tmac_delay #(.W($bits(row_tag_t)), .D(PIPE)) u_tag_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (tag_in),
    .q_o    (tag_d)
  );

  // x and g ride a free-running line sized to the whole cell latency
  logic [SW+CW-1:0] xg_d;
  logic [SW-1:0]    x_d;
  logic [CW-1:0]    g_d;

  tmac_delay #(.W(SW + CW), .D(LAT)) u_xg_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({old_state_i, const_i}),
    .q_o    (xg_d)
  );
  assign {x_d, g_d} = xg_d;

  logic signed [AW-1:0] acc_q, total;
  logic signed [AW-1:0] scaled;
  logic signed [RW-1:0] full;
  logic        [SW-1:0] sat_val;

  always_comb begin
    total   = tag_d.first ? $signed(row_sum) : acc_q + $signed(row_sum);
    scaled  = total >>> FRAC;
    full    = RW'(scaled) + RW'($signed(x_d)) + RW'($signed(g_d));
    if (full > RW'(SMAX))      sat_val = SW'(SMAX);
    else if (full < RW'(SMIN)) sat_val = SW'(SMIN);
    else                       sat_val = SW'(full);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else if (tag_d.valid) acc_q <= total;
  end

  logic [SW-1:0] res_q;
  logic          res_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      res_v_q <= 1'b0;
    end else begin
      res_v_q <= tag_d.valid && tag_d.last;
      if (tag_d.valid && tag_d.last) res_q <= sat_val;
    end
  end

  assign result_o       = res_q;
  assign result_valid_o = res_v_q;
endmodule

// File: rtl/tmac_row_unit_chk.sv
module tmac_row_unit_chk #(
  parameter int NBH = 2,
  parameter int SW  = 16,
  localparam int K  = 2 * NBH + 1,
  localparam int RIW = $clog2(K)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           row_valid_i,
  input logic [RIW-1:0] row_idx,
  input logic           last_row,
  input logic [SW-1:0]  result_o,
  input logic           result_valid_o
);
  logic [7:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else pend_q <= pend_q + {7'd0, last_row} - {7'd0, result_valid_o};
  end

  assert_single_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);

  assert_no_spurious_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> (pend_q != 8'd0));

  assert_result_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> result_valid_o);

  assert_rows_contiguous_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_idx != '0) |-> row_valid_i);

  assert_row_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(row_idx) < K);
endmodule

bind tmac_row_unit tmac_row_unit_chk #(.NBH(NBH), .SW(SW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .row_valid_i    (row_valid_i),
  .row_idx        (row_idx),
  .last_row       (last_row),
  .result_o       (result_o),
  .result_valid_o (result_valid_o)
);

// File: tb/tmac_row_unit_bench.sv
`timescale 1ns/1ps
module tmac_row_unit_bench;
  localparam int NBH = 2, K = 5, SW = 16, TW = 16, CW = 16, FRAC = 8, MUL_LAT = 2;
  localparam int LVL = 3;
  localparam int LAT = K - 1 + MUL_LAT + LVL;
  localparam longint SMAX = 32767, SMIN = -32768;

  typedef logic [K*TW-1:0] row_t;

  logic            clk_i = 1'b0, rst_ni = 1'b0, row_valid_i = 1'b0;
  logic [K*TW-1:0] tmpl_row_i = '0;
  logic [K*SW-1:0] state_row_i = '0;
  logic [CW-1:0]   const_i = '0;
  logic [SW-1:0]   old_state_i = '0;
  logic [SW-1:0]   result_o;
  logic            result_valid_o;

  tmac_row_unit #(.NBH(NBH), .SW(SW), .TW(TW), .CW(CW), .FRAC(FRAC), .MUL_LAT(MUL_LAT))
  u_tmac_row_unit (.*);

  always #2.5 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc++;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  longint exp_q[$];
  int     due_q[$];
  string  req_q[$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // output monitor: value (R2/R3/R5/R7) and timing (R4)
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (result_valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected output", longint'($signed(result_o)), 0);
        end else begin
          check(longint'($signed(result_o)) == exp_q[0], req_q[0],
                longint'($signed(result_o)), exp_q[0]);
          check(cyc == due_q[0], "R4 latency", cyc, due_q[0]);
          void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(req_q.pop_front());
        end
      end else if (due_q.size() != 0 && cyc > due_q[0]) begin
        check(1'b0, "R4 missing pulse", cyc, due_q[0]);
        void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(req_q.pop_front());
      end
    end
  end

  function automatic row_t rand_row(input int mag);
    row_t r;
    for (int j = 0; j < K; j++) r[j*16 +: 16] = 16'($urandom_range(0, 2*mag) - mag);
    return r;
  endfunction

  function automatic longint ref_cell(input row_t t[K], input row_t s[K],
                                      input logic [SW-1:0] x, input logic [CW-1:0] g);
    longint acc = 0, v;
    for (int r = 0; r < K; r++)
      for (int j = 0; j < K; j++)
        acc += longint'($signed(t[r][j*TW +: TW])) * longint'($signed(s[r][j*SW +: SW]));
    v = (acc >>> FRAC) + longint'($signed(x)) + longint'($signed(g));
    if (v > SMAX) v = SMAX;
    if (v < SMIN) v = SMIN;
    return v;
  endfunction

  task automatic drive_row(input row_t t, input row_t s, input logic [SW-1:0] x,
                           input logic [CW-1:0] g, input bit v);
    @(negedge clk_i);
    tmpl_row_i = t; state_row_i = s; old_state_i = x; const_i = g; row_valid_i = v;
  endtask

  task automatic idle(input int n, input bit junk);
    for (int i = 0; i < n; i++)
      if (junk) drive_row(rand_row(32000), rand_row(32000), 16'($urandom), 16'($urandom), 1'b0);
      else      drive_row('0, '0, '0, '0, 1'b0);
  endtask

  // rows on consecutive cycles; junk_xg changes x/g on rows after the first
  task automatic send_cell(input row_t t[K], input row_t s[K], input logic [SW-1:0] x,
                           input logic [CW-1:0] g, input string req, input bit junk_xg);
    for (int r = 0; r < K; r++) begin
      if (r == 0) begin
        drive_row(t[r], s[r], x, g, 1'b1);
        exp_q.push_back(ref_cell(t, s, x, g));
        due_q.push_back(cyc + 1 + LAT);
        req_q.push_back(req);
      end else if (junk_xg) drive_row(t[r], s[r], 16'($urandom), 16'($urandom), 1'b1);
      else drive_row(t[r], s[r], x, g, 1'b1);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 4 * LAT && exp_q.size() != 0; i++) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic rand_cell(output row_t t[K], output row_t s[K]);
    for (int r = 0; r < K; r++) begin
      t[r] = rand_row(256);
      s[r] = rand_row(1024);
    end
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    check(result_valid_o == 1'b0, "R1 valid in reset", longint'(result_valid_o), 0);
    check(result_o == '0, "R1 result in reset", longint'(result_o), 0);
    rst_ni = 1'b1;
    idle(3, 1'b0);
    check(result_valid_o == 1'b0, "R1 valid after reset", longint'(result_valid_o), 0);
    check(result_o == '0, "R1 result after reset", longint'(result_o), 0);
  endtask

  task automatic t_identity();
    row_t t[K], s[K];
    for (int c = 0; c < 3; c++) begin
      for (int r = 0; r < K; r++) begin
        t[r] = '0;
        s[r] = rand_row(3000);
      end
      t[NBH][NBH*TW +: TW] = 16'sd256;
      send_cell(t, s, 16'($urandom_range(0, 200)), 16'($urandom_range(0, 200)), "R2 identity", 1'b0);
      idle(1, 1'b0);
    end
    drain();
  endtask

  task automatic t_random();
    row_t t[K], s[K];
    for (int c = 0; c < 4; c++) begin
      rand_cell(t, s);
      send_cell(t, s, 16'($urandom_range(0, 400) - 200), 16'($urandom_range(0, 400) - 200),
                "R2 random", 1'b0);
      idle(2, 1'b0);
    end
    drain();
  endtask

  task automatic t_back_to_back();
    row_t t[K], s[K];
    for (int c = 0; c < 8; c++) begin
      rand_cell(t, s);
      send_cell(t, s, 16'($urandom), 16'($urandom_range(0, 100)), "R5 back-to-back", 1'b0);
    end
    idle(1, 1'b0);
    drain();
  endtask

  task automatic t_saturate();
    row_t t[K], s[K];
    for (int r = 0; r < K; r++) begin
      t[r] = {K{16'h7fff}};
      s[r] = {K{16'h7fff}};
    end
    send_cell(t, s, 16'd0, 16'd0, "R3 positive clamp", 1'b0);
    for (int r = 0; r < K; r++) t[r] = {K{16'h8000}};
    send_cell(t, s, 16'd0, 16'd0, "R3 negative clamp", 1'b0);
    for (int r = 0; r < K; r++) begin
      t[r] = '0;
      s[r] = '0;
    end
    t[NBH][NBH*TW +: TW] = 16'sd256;
    s[NBH][NBH*SW +: SW] = 16'h7fff;
    send_cell(t, s, 16'd0, 16'd0, "R3 upper bound exact", 1'b0);
    send_cell(t, s, 16'd1, 16'd0, "R3 upper bound plus one", 1'b0);
    s[NBH][NBH*SW +: SW] = 16'h8000;
    send_cell(t, s, 16'd0, 16'd0, "R3 lower bound exact", 1'b0);
    send_cell(t, s, 16'd0, 16'hffff, "R3 lower bound minus one", 1'b0);
    idle(1, 1'b0);
    drain();
  endtask

  task automatic t_gaps();
    row_t t[K], s[K];
    for (int c = 0; c < 4; c++) begin
      rand_cell(t, s);
      send_cell(t, s, 16'($urandom_range(0, 50)), 16'($urandom_range(0, 50)), "R6 gaps with junk", 1'b0);
      idle(1 + c * 3, 1'b1);
    end
    idle(2 * LAT, 1'b1);
    check(exp_q.size() == 0, "R6 no pending after idle", exp_q.size(), 0);
  endtask

  task automatic t_xg_ignored();
    row_t t[K], s[K];
    for (int c = 0; c < 3; c++) begin
      rand_cell(t, s);
      send_cell(t, s, 16'($urandom_range(0, 300)), 16'($urandom_range(0, 300)), "R7 x/g only on first row", 1'b1);
    end
    idle(1, 1'b0);
    drain();
  endtask

  initial begin
    t_reset();
    t_identity();
    t_random();
    t_back_to_back();
    t_saturate();
    t_gaps();
    t_xg_ignored();
    idle(4, 1'b0);
    check(exp_q.size() == 0, "R4 all cells completed", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule